// File: doc/BRIEF.md
# Selectable Decade Timebase

This block turns a 100 kHz reference enable into the gate-timing signal of a frequency counter. Five decade counters run in a chain, and each one steps only when the counter before it rolls over. Each stage therefore marks one decade of time: 10 kHz, 1 kHz, 100 Hz, 10 Hz and 1 Hz. A select code picks one of these decades. The picked decade drives a toggle flop that flips on the falling edge of that tap. The result is a square wave with 50% duty whose high and low phases each last one full tap period.

Everything runs on one system clock. The reference arrives as a single-cycle enable, and the decade taps are produced as clock-enable pulses, not as derived clocks. A per-tap pulse bus reports every rollover of every stage, so nearby logic can use the same timebase.

When the select code changes, the block restarts from zero. This keeps the gate free of runt periods. Codes that name no stage hold the gate low.

Top module: `decade_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, the counters, `gate_out` and `tap_en` all go to zero, and the held select code becomes 0.
- R2: The first stage advances only on cycles where `ref_en` is high. With `ref_en` low, `gate_out` and `tap_en` stay unchanged, apart from the one-cycle clearing of `tap_en`.
- R3: Each stage counts 0 to 9. A stage advances only on the cycle in which the stage before it wraps from 9 to 0. `tap_en[i]` is high for exactly one cycle after each wrap of stage i, so it repeats every 10^(i+1) reference ticks.
- R4: Bit positions of `tap_en` are fixed. Bit 0 is the 10 kHz tap and bit 4 is the 1 Hz tap, which pulses once per 100,000 ticks.
- R5: Select code k (0 to 4) picks stage k. Code 0 is 10 kHz, code 1 is 1 kHz, code 2 is 100 Hz, code 3 is 10 Hz and code 4 is 1 Hz.
- R6: Each tap is high on counts 0 to 4 and low on counts 5 to 9. `gate_out` toggles on the edge where the selected stage steps from 4 to 5. After a restart, its first rise comes 5·10^k ticks later, and each later toggle follows 10^k·10 ticks after the one before.
- R7: One full `gate_out` period is twice the tap period. For example, code 3 gives 20,000 ticks, and code 4 gives two seconds.
- R8: When `tap_sel` differs from the held code at a clock edge, that edge does four things: it clears all counters, clears `gate_out` and `tap_en`, ignores `ref_en`, and takes in the new code.
- R9: Held codes 5, 6 and 7 keep `gate_out` low, while the stages and `tap_en` keep running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle pulse per 100 kHz reference tick |
| tap_sel | input | 3 | Decade select code |
| gate_out | output | 1 | Gate square wave, toggled by the selected tap |
| tap_en | output | 5 | One-cycle rollover pulse per stage, bit 0 fastest |

## Verification
The assertions assume that `ref_en` and `tap_sel` are synchronous to `clk` and never unknown after reset. The stage and chaining properties also assume that a restart clears the counters on the same edge that it takes the new code. The stimulus meets these assumptions by changing inputs only on the falling clock edge. It holds each select code for long stretches, with either dense or sparse reference ticks, and it switches the code in the middle of a count only on purpose, to exercise the restart.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

    localparam int N_STAGES = 5;
    localparam int RADIX    = 10;
    localparam int SEL_BITS = 3;
    localparam int DIGIT_W  = $clog2(RADIX);
    localparam int HALF     = RADIX / 2;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic wrap;   // stage rolls from last digit to zero this cycle
        logic fall;   // stage tap goes from high half to low half
    } stage_ev_t;

    function automatic logic digit_last(input digit_t d);
        return d == digit_t'(RADIX - 1);
    endfunction

    function automatic logic digit_pre_fall(input digit_t d);
        return d == digit_t'(HALF - 1);
    endfunction

endpackage

// File: rtl/dtb_stage.sv
module dtb_stage
    import dtb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      adv_in,
    output stage_ev_t ev_o
);

    digit_t digit_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            digit_q <= '0;
        end else if (adv_in) begin
            digit_q <= digit_last(digit_q) ? '0 : digit_q + digit_t'(1);
        end
    end

    always_comb begin
        ev_o.wrap = adv_in && digit_last(digit_q);
        ev_o.fall = adv_in && digit_pre_fall(digit_q);
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!adv_in && !clr) |=> $stable(digit_q)) else $error("stage moved without advance"); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (adv_in && digit_q == digit_t'(RADIX - 1)) |=> (digit_q == '0)) else $error("stage failed to wrap"); // R3

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (digit_q < digit_t'(RADIX))) else $error("digit out of range"); // R3

endmodule

// File: rtl/dtb_tap_select.sv
module dtb_tap_select
    import dtb_pkg::*;
#(
    parameter int STAGES = N_STAGES,
    parameter int SEL_W  = SEL_BITS
) (
    input  logic [SEL_W-1:0]  sel_code,
    input  logic [STAGES-1:0] falls,
    output logic              sel_ok,
    output logic              pick_fall
);

    always_comb begin
        sel_ok    = 1'b0;
        pick_fall = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (sel_code == SEL_W'(i)) begin
                sel_ok    = 1'b1;
                pick_fall = falls[i];
            end
        end
    end

endmodule

// File: rtl/dtb_gate_toggle.sv
module dtb_gate_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sel_ok,
    input  logic pick_fall,
    output logic gate_q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            gate_q <= 1'b0;
        end else if (!sel_ok) begin
            gate_q <= 1'b0;
        end else if (pick_fall) begin
            gate_q <= ~gate_q;
        end
    end

    AST_INVALID_LOW: assert property (@(posedge clk) disable iff (rst)
        (!sel_ok && !clr) |=> !gate_q) else $error("gate high on invalid code"); // R9

    AST_GATE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (sel_ok && !pick_fall && !clr) |=> $stable(gate_q)) else $error("gate moved off tap edge"); // R6

endmodule

// File: rtl/decade_timebase.sv
module decade_timebase
    import dtb_pkg::*;
#(
    parameter int STAGES = N_STAGES,
    parameter int SEL_W  = SEL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic [SEL_W-1:0]  tap_sel,
    output logic              gate_out,
    output logic [STAGES-1:0] tap_en
);

    logic [SEL_W-1:0]  sel_q;
    logic              restart;
    logic [STAGES-1:0] adv;
    logic [STAGES-1:0] wraps;
    logic [STAGES-1:0] falls;
    logic [STAGES-1:0] tap_en_q;
    logic              sel_ok;
    logic              pick_fall;
    stage_ev_t         ev [STAGES];

    assign restart = (tap_sel != sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (restart) begin
            sel_q <= tap_sel;
        end
    end

    assign adv[0] = ref_en && !restart;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g > 0) begin : g_chain
            assign adv[g] = ev[g-1].wrap;
        end
        dtb_stage u_stage (
            .clk    (clk),
            .rst    (rst),
            .clr    (restart),
            .adv_in (adv[g]),
            .ev_o   (ev[g])
        );
        assign wraps[g] = ev[g].wrap;
        assign falls[g] = ev[g].fall;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tap_en_q <= '0;
        end else begin
            tap_en_q <= wraps;
        end
    end

    dtb_tap_select #(
        .STAGES (STAGES),
        .SEL_W  (SEL_W)
    ) u_select (
        .sel_code  (sel_q),
        .falls     (falls),
        .sel_ok    (sel_ok),
        .pick_fall (pick_fall)
    );

    dtb_gate_toggle u_gate (
        .clk       (clk),
        .rst       (rst),
        .clr       (restart),
        .sel_ok    (sel_ok),
        .pick_fall (pick_fall),
        .gate_q    (gate_out)
    );

    assign tap_en = tap_en_q;

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        restart |=> (gate_out == 1'b0 && tap_en == '0)) else $error("restart left state"); // R8

    AST_IDLE_NO_TAP: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> (tap_en == '0)) else $error("tap pulse without reference"); // R2

    for (genvar h = 1; h < STAGES; h++) begin : g_nest
        AST_TAP_NEST: assert property (@(posedge clk) disable iff (rst)
            tap_en[h] |-> tap_en[h-1]) else $error("slow tap without fast tap"); // R3
    end

endmodule

// File: tb/decade_timebase_tb.sv
module decade_timebase_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b0;
    logic [2:0] tap_sel = 3'd0;
    logic       gate_out;
    logic [4:0] tap_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // reference model state
    longint    m_n = 0;
    int        m_sel = 0;
    bit        m_gate = 0;
    bit [4:0]  m_tap = '0;

    int rises = 0;
    int tap4_pulses = 0;
    bit prev_gate = 0;

    always #10 clk = ~clk;   // 50 MHz

    decade_timebase u_dut (
        .clk      (clk),
        .rst      (rst),
        .ref_en   (ref_en),
        .tap_sel  (tap_sel),
        .gate_out (gate_out),
        .tap_en   (tap_en)
    );

    function automatic longint pw(input int k);
        longint r = 1;
        for (int i = 0; i < k; i++) r = r * 10;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit re, input int sel);
        if (r) begin
            m_n = 0; m_sel = 0; m_gate = 0; m_tap = '0;
        end else if (sel != m_sel) begin
            m_n = 0; m_sel = sel; m_gate = 0; m_tap = '0;
        end else begin
            m_tap = '0;
            if (re) begin
                m_n = m_n + 1;
                for (int j = 0; j < 5; j++)
                    if (m_n % pw(j + 1) == 0) m_tap[j] = 1'b1;
                if (m_sel < 5 && (m_n % pw(m_sel + 1)) == 5 * pw(m_sel))
                    m_gate = ~m_gate;
            end
            if (m_sel >= 5) m_gate = 0;
        end
    endtask

    // drive at negedge, model the following posedge, compare at next negedge
    task automatic step(input bit r, input bit re, input int sel);
        rst = r; ref_en = re; tap_sel = 3'(sel);
        model_step(r, re, sel);
        @(negedge clk);
        chk(gate_out == m_gate, {cur_tag, " gate"}, gate_out, m_gate);
        chk(tap_en == m_tap, {cur_tag, " tap_en"}, tap_en, m_tap);
        if (gate_out && !prev_gate) rises++;
        prev_gate = gate_out;
        if (tap_en[4]) tap4_pulses++;
    endtask

    task automatic run(input int cycles, input int every, input int sel);
        for (int c = 0; c < cycles; c++) step(1'b0, (c % every) == 0, sel);
    endtask

    initial begin
        @(negedge clk);
        cur_tag = "R1";
        for (int c = 0; c < 3; c++) step(1'b1, 1'b1, 3);
        chk(gate_out == 1'b0 && tap_en == 5'd0, "R1 reset outputs", {gate_out, tap_en}, 0);

        cur_tag = "R6 code0";
        run(300, 1, 0);
        cur_tag = "R2 idle";
        run(20, 1000, 0);
        cur_tag = "R5 code1";
        run(2500, 2, 1);
        cur_tag = "R6 code2";
        run(3000, 1, 2);
        cur_tag = "R7 code3";
        rises = 0;
        run(26000, 1, 3);
        chk(rises == 2, "R7 rises code3", rises, 2);
        cur_tag = "R9 invalid";
        run(1500, 1, 6);
        chk(gate_out == 1'b0, "R9 gate low", gate_out, 0);

        cur_tag = "R8 restart";
        run(57, 1, 0);
        step(1'b0, 1'b1, 1);
        chk(gate_out == 1'b0 && tap_en == 5'd0, "R8 cleared", {gate_out, tap_en}, 0);
        run(20, 1, 1);

        cur_tag = "R4 code4";
        rises = 0;
        tap4_pulses = 0;
        run(100005, 1, 4);
        chk(tap4_pulses == 1, "R4 slowest tap", tap4_pulses, 1);
        chk(rises == 1, "R6 code4 rise", rises, 1);
        chk(gate_out == 1'b1, "R7 code4 still high", gate_out, 1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule